// File: doc/BRIEF.md
# Exp-Golomb and Fixed-Length Field Decoder

This block decodes one variable-length field from the head of a left-aligned bitstream window. The window is `WIN_W` bits wide, 32 by default, and its most significant bit is the next unread bit of the stream. In Exp-Golomb mode the field is an order-k codeword, with k between 0 and 3. In fixed-length mode the field is a plain unsigned value of a length the caller requests.

For each accepted window the block reports four results:

- the number of bits the field used, so an upstream pointer accumulator can advance;
- the unsigned code number;
- a signed value mapped from that code number;
- an error flag for a codeword that cannot be decoded.

A small leading-zero detector looks only at the top 16 bits of the window. A single right barrel shifter extracts the field in both modes. In Exp-Golomb mode, the shifter output minus 2^k is the code number.

The block is meant to sit next to a stream shifter. The caller presents a window and a mode each cycle with `in_valid` high. The registered results appear one cycle later and stay in place until the next accepted request.

Top module: `expg_field_dec`

## Requirements
- R1: In Exp-Golomb mode (`fixed_mode`=0), `used_len` equals 2*z + k + 1. Here z is the count of zero bits before the first 1 in `window[31:16]`, and k is `k_order`, which can be 0, 1, 2 or 3.
- R2: In Exp-Golomb mode, `code_num` equals (`window` >> (32 − `used_len`)) − 2^k.
- R3: The leading-zero count depends only on `window[31:16]`. If those 16 bits are all zero in Exp-Golomb mode, `err` is 1 and `used_len`, `code_num` and `se_val` are 0, whatever the lower bits hold.
- R4: In Exp-Golomb mode, a codeword whose length 2*z + k + 1 would exceed 32 bits sets `err` to 1, and the value outputs are 0.
- R5: In fixed-length mode (`fixed_mode`=1), `used_len` equals `fix_len` and `code_num` equals the top `fix_len` bits of `window`, unmodified. `k_order` has no effect, and a window whose top 16 bits are zero is legal.
- R6: In fixed-length mode, a `fix_len` of 0 or greater than 32 sets `err` to 1, with zero outputs.
- R7: `se_val` maps the code number n as follows: an odd n gives +(n+1)/2, and an even n gives −n/2. `se_val` is 33-bit two's complement, and on error it is 0.
- R8: Results and `out_valid` appear on the first rising edge after a cycle with `in_valid` high. After a cycle with `in_valid` low, `out_valid` is 0 and the value outputs keep their previous contents.
- R9: While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Window and mode are valid this cycle |
| fixed_mode | input | 1 | 1 selects fixed-length mode, 0 selects Exp-Golomb mode |
| k_order | input | 2 | Exp-Golomb order k |
| fix_len | input | 6 | Requested field length in fixed-length mode |
| window | input | 32 | Bitstream window, next bit at the MSB |
| out_valid | output | 1 | Results below belong to the last accepted request |
| err | output | 1 | Codeword cannot be decoded |
| used_len | output | 6 | Bits consumed by the field |
| code_num | output | 32 | Unsigned code number or fixed-length value |
| se_val | output | 33 | Signed mapping of `code_num` |

## Verification
Every result of this block is due exactly one rising edge after the cycle in which `in_valid` is high, because the decode path is combinational into a single output register. The bench changes inputs on falling edges and reads the outputs at the following falling edge, half a period after the capturing edge, so each read falls inside the cycle the result belongs to. The idle test drops `in_valid` for one cycle while changing `window`. The bench then reads `out_valid` and the held values at that cycle's next falling edge. The reset checks read the outputs at a falling edge while `rst_n` is still low.

// File: rtl/ued_pkg.sv
package ued_pkg;
   typedef enum logic {
      MODE_EXPG  = 1'b0,
      MODE_FIXED = 1'b1
   } dec_mode_e;
endpackage

// File: rtl/ued_lzd.sv
// Leading-zero detector over a 2*SEG_W-bit slice: OR stage picks the
// half holding the first one, a priority encoder counts within it.
module ued_lzd #(
   parameter  int SEG_W = 8,
   localparam int LZD_W = 2 * SEG_W,
   localparam int PE_W  = $clog2(SEG_W),
   localparam int LZ_W  = PE_W + 1
) (
   input  logic [LZD_W-1:0] bits_i,
   output logic [LZ_W-1:0]  lz_o,
   output logic             all_zero_o
);
   logic [SEG_W-1:0] hi_seg, lo_seg, sel_seg;
   logic             hi_any;
   logic [PE_W-1:0]  pe_cnt;

   generate
      if (SEG_W < 2 || (SEG_W & (SEG_W - 1)) != 0) begin : g_bad_seg
         $error("ued_lzd: SEG_W must be a power of two of at least 2");
      end
   endgenerate

   assign hi_seg  = bits_i[LZD_W-1:SEG_W];
   assign lo_seg  = bits_i[SEG_W-1:0];
   assign hi_any  = |hi_seg;
   assign sel_seg = hi_any ? hi_seg : lo_seg;

   // highest set bit wins: later (higher) indices overwrite lower ones
   always_comb begin
      pe_cnt = '0;
      for (int i = 0; i < SEG_W; i++) begin
         if (sel_seg[i]) pe_cnt = PE_W'(SEG_W - 1 - i);
      end
   end

   assign lz_o       = {~hi_any, pe_cnt};
   assign all_zero_o = ~(hi_any | (|lo_seg));
endmodule

// File: rtl/ued_rshift.sv
// Logarithmic right barrel shifter, one stage per shift-amount bit.
module ued_rshift #(
   parameter  int W    = 32,
   localparam int SH_W = $clog2(W)
) (
   input  logic [W-1:0]    din_i,
   input  logic [SH_W-1:0] shamt_i,
   output logic [W-1:0]    dout_o
);
   logic [W-1:0] stg [SH_W+1];

   assign stg[0] = din_i;

   generate
      for (genvar s = 0; s < SH_W; s++) begin : g_stage
         assign stg[s+1] = shamt_i[s] ? (stg[s] >> (1 << s)) : stg[s];
      end
   endgenerate

   assign dout_o = stg[SH_W];
endmodule

// File: rtl/ued_len_sel.sv
// Field length and error decision for both modes.
module ued_len_sel #(
   parameter int WIN_W = 32,
   parameter int LZ_W  = 4,
   parameter int K_W   = 2,
   parameter int LEN_W = 6
) (
   input  logic             fixed_i,
   input  logic [LZ_W-1:0]  lz_i,
   input  logic             lz_zero_i,
   input  logic [K_W-1:0]   k_i,
   input  logic [LEN_W-1:0] fix_len_i,
   output logic [LEN_W-1:0] len_o,
   output logic             err_o
);
   localparam int EGL_W = LEN_W + 1;

   logic [EGL_W-1:0] eg_len;

   assign eg_len = (EGL_W'(lz_i) << 1) + EGL_W'(k_i) + EGL_W'(1);

   always_comb begin
      if (fixed_i) begin
         len_o = fix_len_i;
         err_o = (fix_len_i == '0) || (fix_len_i > LEN_W'(WIN_W));
      end else begin
         len_o = eg_len[LEN_W-1:0];
         err_o = lz_zero_i || (eg_len > EGL_W'(WIN_W));
      end
   end
endmodule

// File: rtl/expg_field_dec.sv
module expg_field_dec
   import ued_pkg::*;
#(
   parameter  int WIN_W = 32,
   parameter  int SEG_W = 8,
   parameter  int K_W   = 2,
   localparam int LZD_W = 2 * SEG_W,
   localparam int LZ_W  = $clog2(SEG_W) + 1,
   localparam int LEN_W = $clog2(WIN_W + 1),
   localparam int SH_W  = $clog2(WIN_W)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic               fixed_mode,
   input  logic [K_W-1:0]     k_order,
   input  logic [LEN_W-1:0]   fix_len,
   input  logic [WIN_W-1:0]   window,
   output logic               out_valid,
   output logic               err,
   output logic [LEN_W-1:0]   used_len,
   output logic [WIN_W-1:0]   code_num,
   output logic signed [WIN_W:0] se_val
);
   generate
      if (WIN_W < LZD_W) begin : g_bad_win
         $error("expg_field_dec: WIN_W must cover the detector slice");
      end
      if ((WIN_W & (WIN_W - 1)) != 0) begin : g_bad_pow
         $error("expg_field_dec: WIN_W must be a power of two");
      end
      if ((1 << K_W) > WIN_W) begin : g_bad_k
         $error("expg_field_dec: K_W too wide for the window");
      end
   endgenerate

   dec_mode_e         mode;
   logic [LZ_W-1:0]   lz_cnt;
   logic              lz_zero;
   logic [LEN_W-1:0]  len_c;
   logic              err_c;
   logic [SH_W-1:0]   shamt;
   logic [WIN_W-1:0]  shifted;
   logic [WIN_W-1:0]  code_c;
   logic [WIN_W:0]    n_ext;
   logic signed [WIN_W:0] se_c;

   assign mode = fixed_mode ? MODE_FIXED : MODE_EXPG;

   ued_lzd #(.SEG_W(SEG_W)) u_lzd (
      .bits_i     (window[WIN_W-1 -: LZD_W]),
      .lz_o       (lz_cnt),
      .all_zero_o (lz_zero)
   );

   ued_len_sel #(
      .WIN_W (WIN_W),
      .LZ_W  (LZ_W),
      .K_W   (K_W),
      .LEN_W (LEN_W)
   ) u_len (
      .fixed_i   (mode == MODE_FIXED),
      .lz_i      (lz_cnt),
      .lz_zero_i (lz_zero),
      .k_i       (k_order),
      .fix_len_i (fix_len),
      .len_o     (len_c),
      .err_o     (err_c)
   );

   // shift right by (WIN_W - len); len in 1..WIN_W gives 0..WIN_W-1
   assign shamt = err_c ? '0 : SH_W'(LEN_W'(WIN_W) - len_c);

   ued_rshift #(.W(WIN_W)) u_shift (
      .din_i   (window),
      .shamt_i (shamt),
      .dout_o  (shifted)
   );

   always_comb begin
      if (err_c)
         code_c = '0;
      else if (mode == MODE_FIXED)
         code_c = shifted;
      else
         code_c = shifted - (WIN_W'(1) << k_order);
   end

   assign n_ext = {1'b0, code_c};

   always_comb begin
      if (code_c[0])
         se_c = signed'((n_ext + (WIN_W+1)'(1)) >> 1);
      else
         se_c = signed'((WIN_W+1)'(0) - (n_ext >> 1));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         err       <= 1'b0;
         used_len  <= '0;
         code_num  <= '0;
         se_val    <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            err      <= err_c;
            used_len <= err_c ? '0 : len_c;
            code_num <= code_c;
            se_val   <= se_c;
         end
      end
   end

   AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid); // R8
   AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid); // R8
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(code_num) && $stable(used_len) && $stable(se_val))); // R8
   AST_ERR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && err) |-> (used_len == '0 && code_num == '0 && se_val == '0)); // R3
   AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !err) |-> (used_len != '0 && used_len <= LEN_W'(WIN_W))); // R4
   AST_SE_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !err) |-> (se_val[WIN_W] == (!code_num[0] && code_num != '0))); // R7
endmodule

// File: tb/expg_field_dec_tb.sv
module expg_field_dec_tb;
   typedef struct packed {
      logic        fx;
      logic [1:0]  k;
      logic [5:0]  flen;
      logic [31:0] win;
      logic        e_err;
      logic [5:0]  e_len;
      logic [31:0] e_code;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t TBL [NV] = '{
      '{1'b0, 2'd0, 6'd0,  32'h8000_0000, 1'b0, 6'd1,  32'd0},      // R1 R2
      '{1'b0, 2'd0, 6'd0,  32'h4000_0000, 1'b0, 6'd3,  32'd1},      // R2
      '{1'b0, 2'd0, 6'd0,  32'h6000_0000, 1'b0, 6'd3,  32'd2},      // R2
      '{1'b0, 2'd1, 6'd0,  32'h8000_0000, 1'b0, 6'd2,  32'd0},      // R1
      '{1'b0, 2'd1, 6'd0,  32'hC000_0000, 1'b0, 6'd2,  32'd1},      // R2
      '{1'b0, 2'd2, 6'd0,  32'h2A00_0000, 1'b0, 6'd7,  32'd17},     // R1
      '{1'b0, 2'd3, 6'd0,  32'h0001_8000, 1'b1, 6'd0,  32'd0},      // R4
      '{1'b0, 2'd0, 6'd0,  32'h0001_FFFF, 1'b0, 6'd31, 32'd65534},  // R1
      '{1'b0, 2'd1, 6'd0,  32'h0001_0003, 1'b0, 6'd32, 32'd65537},  // R2
      '{1'b0, 2'd2, 6'd0,  32'h0000_FFFF, 1'b1, 6'd0,  32'd0},      // R3
      '{1'b1, 2'd3, 6'd5,  32'hB800_0000, 1'b0, 6'd5,  32'd23},     // R5
      '{1'b1, 2'd0, 6'd32, 32'hDEAD_BEEF, 1'b0, 6'd32, 32'hDEAD_BEEF}, // R5
      '{1'b1, 2'd0, 6'd0,  32'hFFFF_FFFF, 1'b1, 6'd0,  32'd0},      // R6
      '{1'b1, 2'd1, 6'd33, 32'hFFFF_FFFF, 1'b1, 6'd0,  32'd0},      // R6
      '{1'b1, 2'd2, 6'd1,  32'h0000_0000, 1'b0, 6'd1,  32'd0},      // R5
      '{1'b0, 2'd3, 6'd0,  32'h1000_0000, 1'b0, 6'd10, 32'd56}      // R1
   };

   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid;
   logic        fixed_mode;
   logic [1:0]  k_order;
   logic [5:0]  fix_len;
   logic [31:0] window;
   logic        out_valid;
   logic        err;
   logic [5:0]  used_len;
   logic [31:0] code_num;
   logic signed [32:0] se_val;

   int checks   = 0;
   int failures = 0;
   bit done     = 1'b0;

   always #2 clk = ~clk;

   expg_field_dec u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .fixed_mode (fixed_mode),
      .k_order    (k_order),
      .fix_len    (fix_len),
      .window     (window),
      .out_valid  (out_valid),
      .err        (err),
      .used_len   (used_len),
      .code_num   (code_num),
      .se_val     (se_val)
   );

   function automatic logic [32:0] exp_se(input logic [31:0] n, input logic e);
      logic [32:0] w;
      w = {1'b0, n};
      if (e)         return 33'd0;
      else if (n[0]) return (w + 33'd1) / 2;
      else           return 33'd0 - (w / 2);
   endfunction

   task automatic chk(input bit ok, input string tag,
                      input logic [63:0] act, input logic [63:0] expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
      end
   endtask

   initial begin
      #400000;
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [31:0] last_code;
      rst_n = 1'b0; in_valid = 1'b0; fixed_mode = 1'b0;
      k_order = '0; fix_len = '0; window = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R9 reset state
      chk(out_valid == 1'b0, "R9 out_valid", 64'(out_valid), 0);
      chk(err == 1'b0 && used_len == 0, "R9 err/len", {err, used_len}, 0);
      chk(code_num == 0 && se_val == 0, "R9 values", 64'(code_num), 0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         in_valid   = 1'b1;
         fixed_mode = TBL[i].fx;
         k_order    = TBL[i].k;
         fix_len    = TBL[i].flen;
         window     = TBL[i].win;
         @(posedge clk);
         @(negedge clk);
         chk(out_valid == 1'b1, "R8 out_valid", 64'(out_valid), 1);
         chk(err == TBL[i].e_err, "R3 R4 R6 err", 64'(err), 64'(TBL[i].e_err));
         chk(used_len == TBL[i].e_len, "R1 R5 used_len", 64'(used_len), 64'(TBL[i].e_len));
         chk(code_num == TBL[i].e_code, "R2 R5 code_num", 64'(code_num), 64'(TBL[i].e_code));
         chk(se_val == exp_se(TBL[i].e_code, TBL[i].e_err), "R7 se_val",
             64'(se_val), 64'(exp_se(TBL[i].e_code, TBL[i].e_err)));
      end
      last_code = TBL[NV-1].e_code;

      // R8 idle cycle: inputs change, outputs hold
      in_valid = 1'b0;
      window   = 32'h4000_0000;
      k_order  = 2'd0;
      fixed_mode = 1'b0;
      @(posedge clk);
      @(negedge clk);
      chk(out_valid == 1'b0, "R8 idle out_valid", 64'(out_valid), 0);
      chk(code_num == last_code, "R8 idle hold", 64'(code_num), 64'(last_code));
      chk(used_len == 6'd10, "R8 idle len hold", 64'(used_len), 10);

      // R3 lower bits ignored by zero detection, then R9 reset mid-run
      in_valid = 1'b1;
      window   = 32'h0000_8001;
      k_order  = 2'd1;
      @(posedge clk);
      @(negedge clk);
      chk(err == 1'b1 && code_num == 0, "R3 low bits", {err, code_num}, 64'h1_0000_0000);
      in_valid = 1'b1;
      window   = 32'h8000_0000;
      k_order  = 2'd0;
      rst_n    = 1'b0;
      @(posedge clk);
      @(negedge clk);
      chk(out_valid == 1'b0 && err == 1'b0 && code_num == 0, "R9 mid reset",
          {out_valid, err, code_num}, 0);
      rst_n = 1'b1;
      in_valid = 1'b0;
      @(negedge clk);

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule